// File: doc/BRIEF.md
# USB Host Pipe Status Controller

This block keeps the live status of one pipe of a USB host controller: a data-toggle bit, a pointer to the bank the next packet will use, a freeze flag that stops the pipe, and a ready flag for each of the two packet banks. Software changes the bank-ready, freeze and toggle bits through a pair of strobe vectors. Each set bit of one vector forces its status bit to one, and each set bit of the other forces it to zero. The packet engine reports protocol events on single-cycle inputs, and the block moves the same bits on its own in response.

A freeze can be requested by software or by the protocol. It is never applied in the middle of a bus transaction. The request is held until the bus is idle, and only then does the freeze bit appear. While the bit is set, the pipe is barred from issuing new requests. The toggle bit and the bank pointer advance with every completed data packet. On a control pipe, only bank 0 is ever used.

Top module: `pipe_status_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00. The layout is: bit 0 data toggle (0 = DATA0 expected next, 1 = DATA1), bit 2 current bank, bit 4 freeze, bit 6 bank-0 ready, bit 7 bank-1 ready. Bits 1, 3 and 5 always read zero.
- R2: A one in bit 0, 4, 6 or 7 of the set strobe vector sets that status bit on the next clock. A one in the same bit of the clear strobe vector clears it. When both are high on one bit, clear wins. Zero strobe bits, and strobe bits 1, 2, 3 and 5, have no effect.
- R3: A freeze request is raised by a STALL handshake, by a 0-to-1 edge of pipe enable (a steady high level does not raise one), by completion of a link-power-management transaction, or by a pipe error.
- R4: A freeze request made while the bus-busy input is high is held. The freeze bit reads 1 on the clock that follows the first cycle in which bus-busy is low. A request made while the bus is idle shows on the next clock.
- R5: A software clear of freeze clears the bit and cancels any held request. It takes priority over a same-cycle hardware event or software set.
- R6: issue_ok_o is high exactly when pipe enable is high and the freeze bit is 0.
- R7: Each completed data packet flips the toggle bit. A software set or clear of the toggle bit in the same cycle takes priority over the flip.
- R8: On a non-control pipe with dual banking, the current bank alternates after each completed packet. With single banking, or on a control pipe, it is 0 from the next clock.
- R9: A completed IN packet sets the ready flag of the bank the current-bank bit selected. A completed OUT or control packet clears that flag. A software strobe on that flag in the same cycle takes priority.
- R10: On a control pipe, bank-1 ready reads 0 from the next clock, whatever the strobes or events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_set_i | input | STAT_W | Set strobes, one per status bit position |
| sw_clr_i | input | STAT_W | Clear strobes, one per status bit position |
| pipe_en_i | input | 1 | Pipe enable level |
| ctl_pipe_i | input | 1 | Pipe is a control pipe |
| dual_bank_i | input | 1 | Dual banking enabled |
| stall_i | input | 1 | STALL handshake received (pulse) |
| lpm_done_i | input | 1 | Link-power-management transaction ended, for any handshake or on timeout (pulse) |
| pipe_err_i | input | 1 | Transfer ended with a pipe error (pulse) |
| bus_busy_i | input | 1 | A bus transaction is in flight |
| pkt_done_i | input | 1 | Data packet completed successfully (pulse) |
| pkt_in_i | input | 1 | Completed packet was IN (1) or OUT/control (0) |
| status_o | output | STAT_W | Status view |
| issue_ok_o | output | 1 | Pipe may issue a new request |

## Verification
The risky coincidences are a freeze cause arriving in the same cycle as a software clear of freeze, and a packet completion arriving in the same cycle as a software strobe on the toggle or on the ready flag of the bank in use. The bench forces each of these in directed steps, including a clear that lands while a request is held behind a busy bus. It then runs a long random phase with dense strobes, events and busy cycles so that such overlaps recur many times. On every clock the behavioural model, which gives software the priority that R2, R5, R7 and R9 state, is compared with each status bit and with issue_ok_o.

// File: rtl/pstat_pkg.sv
package pstat_pkg;
    localparam int STAT_W_DEF = 8;
    localparam int TGL_BIT    = 0;
    localparam int CUR_BIT    = 2;
    localparam int FRZ_BIT    = 4;
    localparam int RDY0_BIT   = 6;
    localparam int NUM_BANKS  = 2;

    typedef struct packed {
        logic pend;
        logic frz;
        logic en_prev;
    } frz_state_t;

    typedef struct packed {
        logic tgl;
        logic cur;
    } seq_state_t;
endpackage

// File: rtl/pstat_freeze.sv
module pstat_freeze
    import pstat_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sw_set_i,
    input  logic sw_clr_i,
    input  logic pipe_en_i,
    input  logic stall_i,
    input  logic lpm_done_i,
    input  logic pipe_err_i,
    input  logic busy_i,
    output logic frozen_o
);
    frz_state_t st_d, st_q;
    logic       req;
    logic       want;

    always_comb begin
        st_d         = st_q;
        st_d.en_prev = pipe_en_i;
        req  = sw_set_i | stall_i | lpm_done_i | pipe_err_i | (pipe_en_i & ~st_q.en_prev);
        want = st_q.pend | req;
        if (sw_clr_i) begin
            st_d.frz  = 1'b0;
            st_d.pend = 1'b0;
        end else if (want && !busy_i) begin
            st_d.frz  = 1'b1;
            st_d.pend = 1'b0;
        end else if (want) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign frozen_o = st_q.frz;

    assert_freeze_after_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.frz) |-> !$past(busy_i));

    assert_clear_cancels_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sw_clr_i |=> (!st_q.frz && !st_q.pend));

    assert_stall_freezes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stall_i && !busy_i && !sw_clr_i) |=> st_q.frz);

    assert_held_request_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pipe_err_i && busy_i && !sw_clr_i) |=> st_q.pend);
endmodule

// File: rtl/pstat_seq.sv
module pstat_seq
    import pstat_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tgl_set_i,
    input  logic tgl_clr_i,
    input  logic pkt_done_i,
    input  logic ctl_pipe_i,
    input  logic dual_bank_i,
    output logic tgl_o,
    output logic cur_o
);
    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tgl_clr_i)       st_d.tgl = 1'b0;
        else if (tgl_set_i)  st_d.tgl = 1'b1;
        else if (pkt_done_i) st_d.tgl = ~st_q.tgl;

        if (ctl_pipe_i || !dual_bank_i) st_d.cur = 1'b0;
        else if (pkt_done_i)            st_d.cur = ~st_q.cur;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign tgl_o = st_q.tgl;
    assign cur_o = st_q.cur;

    assert_toggle_flips_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pkt_done_i && !tgl_set_i && !tgl_clr_i) |=> (tgl_o != $past(tgl_o)));

    assert_single_bank_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_pipe_i || !dual_bank_i) |=> !cur_o);

    assert_bank_alternates_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pkt_done_i && dual_bank_i && !ctl_pipe_i) |=> (cur_o != $past(cur_o)));
endmodule

// File: rtl/pstat_bank.sv
module pstat_bank #(
    parameter int BANK_IDX = 0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rdy_set_i,
    input  logic rdy_clr_i,
    input  logic pkt_done_i,
    input  logic pkt_in_i,
    input  logic cur_bank_i,
    input  logic ctl_pipe_i,
    output logic rdy_o
);
    localparam logic MY_SEL  = 1'(BANK_IDX);
    localparam bit   CTL_OFF = (BANK_IDX != 0);

    logic rdy_d, rdy_q;
    logic hit;

    always_comb begin
        hit   = pkt_done_i && (cur_bank_i == MY_SEL);
        rdy_d = rdy_q;
        if (CTL_OFF && ctl_pipe_i) rdy_d = 1'b0;
        else if (rdy_clr_i)        rdy_d = 1'b0;
        else if (rdy_set_i)        rdy_d = 1'b1;
        else if (hit)              rdy_d = pkt_in_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rdy_q <= 1'b0;
        else         rdy_q <= rdy_d;
    end

    assign rdy_o = rdy_q;

    assert_in_marks_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pkt_done_i && pkt_in_i && cur_bank_i == MY_SEL && !rdy_clr_i
         && !(CTL_OFF && ctl_pipe_i)) |=> rdy_o);

    assert_out_empties_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pkt_done_i && !pkt_in_i && cur_bank_i == MY_SEL && !rdy_set_i) |=> !rdy_o);

    if (CTL_OFF) begin : g_ctl_chk
        assert_ctl_no_bank1_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ctl_pipe_i |=> !rdy_o);
    end
endmodule

// File: rtl/pipe_status_ctrl.sv
module pipe_status_ctrl
    import pstat_pkg::*;
#(
    parameter int STAT_W = STAT_W_DEF
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [STAT_W-1:0] sw_set_i,
    input  logic [STAT_W-1:0] sw_clr_i,
    input  logic              pipe_en_i,
    input  logic              ctl_pipe_i,
    input  logic              dual_bank_i,
    input  logic              stall_i,
    input  logic              lpm_done_i,
    input  logic              pipe_err_i,
    input  logic              bus_busy_i,
    input  logic              pkt_done_i,
    input  logic              pkt_in_i,
    output logic [STAT_W-1:0] status_o,
    output logic              issue_ok_o
);
    localparam int LAST_RDY = RDY0_BIT + NUM_BANKS - 1;

    logic                 frozen;
    logic                 tgl;
    logic                 cur;
    logic [NUM_BANKS-1:0] rdy;

    pstat_freeze u_freeze (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sw_set_i   (sw_set_i[FRZ_BIT]),
        .sw_clr_i   (sw_clr_i[FRZ_BIT]),
        .pipe_en_i  (pipe_en_i),
        .stall_i    (stall_i),
        .lpm_done_i (lpm_done_i),
        .pipe_err_i (pipe_err_i),
        .busy_i     (bus_busy_i),
        .frozen_o   (frozen)
    );

    pstat_seq u_seq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tgl_set_i   (sw_set_i[TGL_BIT]),
        .tgl_clr_i   (sw_clr_i[TGL_BIT]),
        .pkt_done_i  (pkt_done_i),
        .ctl_pipe_i  (ctl_pipe_i),
        .dual_bank_i (dual_bank_i),
        .tgl_o       (tgl),
        .cur_o       (cur)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        pstat_bank #(.BANK_IDX(b)) u_bank (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .rdy_set_i  (sw_set_i[RDY0_BIT+b]),
            .rdy_clr_i  (sw_clr_i[RDY0_BIT+b]),
            .pkt_done_i (pkt_done_i),
            .pkt_in_i   (pkt_in_i),
            .cur_bank_i (cur),
            .ctl_pipe_i (ctl_pipe_i),
            .rdy_o      (rdy[b])
        );
    end

    always_comb begin
        status_o                    = '0;
        status_o[TGL_BIT]           = tgl;
        status_o[CUR_BIT]           = cur;
        status_o[FRZ_BIT]           = frozen;
        status_o[LAST_RDY:RDY0_BIT] = rdy;
    end

    assign issue_ok_o = pipe_en_i & ~frozen;

    assert_strobe_clear_wins_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sw_clr_i[TGL_BIT] && sw_set_i[TGL_BIT]) |=> !status_o[TGL_BIT]);

    assert_set_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sw_set_i[RDY0_BIT] && !sw_clr_i[RDY0_BIT]) |=> status_o[RDY0_BIT]);
endmodule

// File: tb/test_pipe_status_ctrl.sv
`timescale 1ns/1ps
module test_pipe_status_ctrl;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] sset = '0, sclr = '0;
    logic         en = 0, ctl = 0, dbl = 1, stall = 0, lpm = 0, err = 0;
    logic         busy = 0, done = 0, dirin = 0;
    logic [W-1:0] status;
    logic         issue_ok;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;

    bit m_tgl, m_cur, m_frz, m_pend, m_enp, m_r0, m_r1, m_used, m_req;

    always #2 clk = ~clk;

    pipe_status_ctrl #(.STAT_W(W)) i_pipe_status_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .sw_set_i(sset), .sw_clr_i(sclr),
        .pipe_en_i(en), .ctl_pipe_i(ctl), .dual_bank_i(dbl), .stall_i(stall),
        .lpm_done_i(lpm), .pipe_err_i(err), .bus_busy_i(busy),
        .pkt_done_i(done), .pkt_in_i(dirin), .status_o(status), .issue_ok_o(issue_ok)
    );

    // behavioural reference, evaluated on the rising edge from the inputs in effect
    always @(posedge clk) begin
        if (!rst_n) begin
            {m_tgl, m_cur, m_frz, m_pend, m_enp, m_r0, m_r1} = '0;
        end else begin
            m_used = m_cur;
            m_req  = sset[4] | stall | lpm | err | (en & !m_enp);
            if (sclr[4]) begin m_frz = 0; m_pend = 0; end
            else if ((m_pend | m_req) && !busy) begin m_frz = 1; m_pend = 0; end
            else if (m_pend | m_req) m_pend = 1;
            if (sclr[0]) m_tgl = 0; else if (sset[0]) m_tgl = 1; else if (done) m_tgl = !m_tgl;
            if (sclr[6]) m_r0 = 0; else if (sset[6]) m_r0 = 1;
            else if (done && !m_used) m_r0 = dirin;
            if (ctl) m_r1 = 0; else if (sclr[7]) m_r1 = 0; else if (sset[7]) m_r1 = 1;
            else if (done && m_used) m_r1 = dirin;
            if (ctl || !dbl) m_cur = 0; else if (done) m_cur = !m_cur;
            m_enp = en;
        end
    end

    task automatic cmp(input logic act, input logic exp, input string req);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s at cycle %0d: actual %b expected %b", req, cyc, act, exp);
        end
    endtask

    // compare every cycle, 1 ns after the falling edge
    always begin
        @(negedge clk);
        #1;
        if (!rst_n) begin
            cmp(status == 8'h00, 1'b1, "R1 reset");
        end else begin
            cmp(status[0], m_tgl, "R7 toggle");
            cmp(status[2], m_cur, "R8 bank");
            cmp(status[4], m_frz, "R3/R4/R5 freeze");
            cmp(status[6], m_r0, "R9 bank0");
            cmp(status[7], m_r1, "R10/R9 bank1");
            cmp(status[1] | status[3] | status[5], 1'b0, "R1 unused");
            cmp(issue_ok, en & !m_frz, "R6 issue");
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            miscompares++;
            $display("FAIL watchdog expired at cycle %0d: actual hang expected finish", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_pulses();
        sset = '0; sclr = '0; stall = 0; lpm = 0; err = 0; done = 0;
    endtask

    task automatic frz_clear();
        sclr[4] = 1; tick(1); clear_pulses();
    endtask

    initial begin
        tick(3);
        rst_n = 1;
        tick(2);
        cmp(status == 8'h00, 1'b1, "R1 after reset");

        // R2: set everything, unused and bank-pointer bits ignored
        sset = 8'hFF; tick(1); clear_pulses();
        cmp(status == 8'hD1, 1'b1, "R2 set all");
        sset = 8'hFF; sclr = 8'hFF; tick(1); clear_pulses();
        cmp(status == 8'h00, 1'b1, "R2 clear wins");
        tick(1);

        // R3: each freeze cause
        stall = 1; tick(1); clear_pulses(); cmp(status[4], 1'b1, "R3 stall"); frz_clear();
        lpm = 1;   tick(1); clear_pulses(); cmp(status[4], 1'b1, "R3 lpm");   frz_clear();
        err = 1;   tick(1); clear_pulses(); cmp(status[4], 1'b1, "R3 error"); frz_clear();
        en = 1;    tick(1);                 cmp(status[4], 1'b1, "R3 enable edge");
        frz_clear(); tick(3);
        cmp(status[4], 1'b0, "R3 level does not refreeze");

        // R4: deferral behind a busy bus
        busy = 1; stall = 1; tick(1); clear_pulses(); tick(3);
        cmp(status[4], 1'b0, "R4 held while busy");
        busy = 0; tick(1);
        cmp(status[4], 1'b1, "R4 appears after idle");
        frz_clear();

        // R5: clear cancels held request, and beats same-cycle event
        busy = 1; err = 1; tick(1); clear_pulses();
        sclr[4] = 1; tick(1); clear_pulses();
        busy = 0; tick(2);
        cmp(status[4], 1'b0, "R5 cancel held");
        stall = 1; sclr[4] = 1; tick(1); clear_pulses();
        cmp(status[4], 1'b0, "R5 clear beats stall");

        // R7 / R8 / R9: packets on a dual-bank IN pipe
        dirin = 1; done = 1; tick(1); clear_pulses();
        cmp(status[0], 1'b1, "R7 flip");
        cmp(status[6], 1'b1, "R9 bank0 ready");
        cmp(status[2], 1'b1, "R8 alternate");
        done = 1; sset[0] = 1; tick(1); clear_pulses();
        cmp(status[0], 1'b1, "R7 set beats flip");
        cmp(status[7], 1'b1, "R9 bank1 ready");
        dirin = 0; done = 1; sset[6] = 1; tick(1); clear_pulses();
        cmp(status[6], 1'b1, "R9 strobe beats OUT");
        done = 1; tick(1); clear_pulses();
        cmp(status[7], 1'b0, "R9 OUT empties bank1");
        dbl = 0; done = 1; tick(2); clear_pulses();
        cmp(status[2], 1'b0, "R8 single bank");

        // R10: control pipe
        dbl = 1; ctl = 1; sset[7] = 1; tick(1); clear_pulses(); tick(1);
        cmp(status[7], 1'b0, "R10 bank1 stays 0");
        cmp(status[2], 1'b0, "R10 bank0 only");

        // random phase, compared against the model every cycle
        for (int i = 0; i < 4000; i++) begin
            sset  = ($urandom_range(0, 5) == 0) ? W'($urandom) : '0;
            sclr  = ($urandom_range(0, 5) == 0) ? W'($urandom) : '0;
            stall = ($urandom_range(0, 15) == 0);
            lpm   = ($urandom_range(0, 20) == 0);
            err   = ($urandom_range(0, 20) == 0);
            done  = ($urandom_range(0, 2) == 0);
            dirin = $urandom_range(0, 1);
            busy  = ($urandom_range(0, 2) != 0);
            if ($urandom_range(0, 40) == 0) en  = ~en;
            if ($urandom_range(0, 150) == 0) ctl = ~ctl;
            if ($urandom_range(0, 150) == 0) dbl = ~dbl;
            tick(1);
        end
        clear_pulses();
        tick(2);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule